// File: doc/BRIEF.md
# Stereo Codec Mixer Control Register File

This block holds the control registers of a stereo audio codec. Software reaches it through a simple synchronous register bus. The bus has a write strobe, a read strobe, a 7-bit register index, and 16-bit write and read data. The block decodes the stored master volume into left and right attenuation codes. It also produces left and right mute signals that an analog or digital output stage consumes directly.

The block implements four registers:

| Index | Role |
|-------|------|
| 0x00 | Identification word and soft reset |
| 0x02 | Master volume |
| 0x74 | Serial configuration |
| 0x76 | Miscellaneous control, including the split-mute enable |

Writing any value to index 0x00 returns the register file to its defaults, but the serial configuration register keeps its contents across this soft reset.

The master volume register stays compatible with software that writes 6-bit volume fields. When the sixth bit of a field is set, the five stored bits become all ones, which is the deepest attenuation. The split-mute enable chooses between two mute schemes: one global mute, or separate mutes for the left and right channels.

Top module: `mixreg_top`

## Requirements
- R1: While `rst` is high, and after it is released, the registers hold their defaults: master volume 0x8000, serial configuration 0x0000 and miscellaneous control 0x0000. As a result, `att_left` and `att_right` are 0, both mutes are 1 and `rd_data` is 0x0000.
- R2: A read of index 0x00 always returns 0x0090.
- R3: In the master volume register (index 0x02), bit 15 is the master mute, bits 12:8 are the left attenuation and bits 4:0 are the right attenuation. The stored codes appear on `att_left` and `att_right` and read back in the same positions. Code n means n × 1.5 dB of attenuation.
- R4: A master volume write with bit 13 set stores a left attenuation of 31. A write with bit 5 set stores a right attenuation of 31. Readback shows the all-ones field.
- R5: Bits 14, 13, 6 and 5 of the master volume register always read 0.
- R6: When bit 12 of index 0x76 (split-mute enable) is 0, bit 7 of the master volume register reads 0 and has no effect, and the master mute drives both `mute_left` and `mute_right`.
- R7: When the split-mute enable is 1, the master mute drives only `mute_left`. Bit 7 of the master volume register drives `mute_right` and reads back as written.
- R8: A write to index 0x00 with any data returns the master volume register to 0x8000 and index 0x76 to 0x0000.
- R9: Indices 0x74 and 0x76 store all 16 written bits and read them back unchanged. A write to index 0x00 leaves index 0x74 unchanged.
- R10: A read of any index other than 0x00, 0x02, 0x74 and 0x76 returns 0x0000. A write to such an index changes no state.
- R11: `rd_data` presents the addressed register one clock after the edge that samples `rd_en`, and holds its value while `rd_en` is low. A write is visible to a read strobed on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 7 | Register index |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Registered read data |
| att_left | output | 5 | Left attenuation code |
| att_right | output | 5 | Right attenuation code |
| mute_left | output | 1 | Effective left mute |
| mute_right | output | 1 | Effective right mute |

## Verification
A wrong stored field shows up on the attenuation or mute ports in the first cycle after the write. It also shows up on `rd_data` one cycle after the next read strobe, so each write in the bench is followed at once by a port check and a readback.

A soft reset that clears too much, or too little, first becomes visible on the readback of the serial configuration and miscellaneous registers. Misrouted mutes show only in some combinations of the split enable, master mute and right mute. For that reason, all eight combinations are driven, and each one is checked on both mute ports.

// File: rtl/mixreg_pkg.sv
package mixreg_pkg;

    localparam int ADDR_W = 7;
    localparam int DATA_W = 16;
    localparam int ATT_W  = 5;

    localparam logic [ADDR_W-1:0] IDX_IDENT  = 7'h00;
    localparam logic [ADDR_W-1:0] IDX_MASTER = 7'h02;
    localparam logic [ADDR_W-1:0] IDX_SERIAL = 7'h74;
    localparam logic [ADDR_W-1:0] IDX_MISC   = 7'h76;

    localparam logic [DATA_W-1:0] IDENT_WORD     = 16'h0090;
    localparam logic [DATA_W-1:0] MASTER_DEFAULT = 16'h8000;
    localparam logic [DATA_W-1:0] SERIAL_DEFAULT = 16'h0000;
    localparam logic [DATA_W-1:0] MISC_DEFAULT   = 16'h0000;

    localparam int SPLIT_BIT = 12;

    // Stored state of the master volume register (legacy bits are not kept).
    typedef struct packed {
        logic             mute_main;
        logic [ATT_W-1:0] att_l;
        logic             mute_r;
        logic [ATT_W-1:0] att_r;
    } master_t;

    // One-hot register select.
    typedef struct packed {
        logic ident;
        logic master;
        logic serial;
        logic misc;
    } sel_t;

    localparam master_t MASTER_RST = '{mute_main: 1'b1, att_l: '0, mute_r: 1'b0, att_r: '0};

    function automatic master_t master_from_bus(input logic [DATA_W-1:0] d);
        master_t m;
        m.mute_main = d[15];
        m.att_l     = d[13] ? {ATT_W{1'b1}} : d[12:8];
        m.mute_r    = d[7];
        m.att_r     = d[5] ? {ATT_W{1'b1}} : d[4:0];
        return m;
    endfunction

    function automatic logic [DATA_W-1:0] master_to_bus(input master_t m, input logic split);
        return {m.mute_main, 2'b00, m.att_l, m.mute_r & split, 2'b00, m.att_r};
    endfunction

    function automatic sel_t decode_index(input logic [ADDR_W-1:0] a);
        sel_t s;
        s.ident  = (a == IDX_IDENT);
        s.master = (a == IDX_MASTER);
        s.serial = (a == IDX_SERIAL);
        s.misc   = (a == IDX_MISC);
        return s;
    endfunction

endpackage

// File: rtl/mixreg_decode.sv
module mixreg_decode
    import mixreg_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic [AW-1:0] addr,
    output sel_t          sel,
    output logic          hit
);
    always_comb begin
        sel = decode_index(addr);
        hit = |sel;
    end

    always_comb begin
        a_r10_sel_onehot: assert ($onehot0(sel));
    end
endmodule

// File: rtl/mixreg_store.sv
module mixreg_store
    import mixreg_pkg::*;
#(
    parameter int                W            = DATA_W,
    parameter logic [W-1:0]      DEFAULT      = '0,
    parameter bit                KEEP_ON_SOFT = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         soft_clr,
    input  logic         we,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    generate
        if (KEEP_ON_SOFT) begin : g_keep
            always_ff @(posedge clk) begin
                if (rst)     q <= DEFAULT;
                else if (we) q <= d;
            end

            // R9: soft reset leaves this register untouched
            a_r9_keep_on_soft: assert property (@(posedge clk) disable iff (rst)
                soft_clr |=> $stable(q));
        end else begin : g_clear
            always_ff @(posedge clk) begin
                if (rst || soft_clr) q <= DEFAULT;
                else if (we)         q <= d;
            end

            a_r8_clear_on_soft: assert property (@(posedge clk) disable iff (rst)
                soft_clr |=> (q == DEFAULT));
        end
    endgenerate

    a_r9_hold_idle: assert property (@(posedge clk) disable iff (rst)
        (!we && !soft_clr) |=> $stable(q));
endmodule

// File: rtl/mixreg_master.sv
module mixreg_master
    import mixreg_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AT = ATT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          soft_clr,
    input  logic          we,
    input  logic [DW-1:0] wr_data,
    input  logic          split,
    output logic [DW-1:0] rd_word,
    output logic [AT-1:0] att_left,
    output logic [AT-1:0] att_right,
    output logic          mute_left,
    output logic          mute_right
);
    master_t st;

    always_ff @(posedge clk) begin
        if (rst || soft_clr) st <= MASTER_RST;
        else if (we)         st <= master_from_bus(wr_data);
    end

    always_comb begin
        rd_word    = master_to_bus(st, split);
        att_left   = st.att_l;
        att_right  = st.att_r;
        mute_left  = st.mute_main;
        mute_right = split ? st.mute_r : st.mute_main;
    end

    a_r4_left_saturate: assert property (@(posedge clk) disable iff (rst)
        (we && !soft_clr && wr_data[13]) |=> (att_left == {AT{1'b1}}));
    a_r4_right_saturate: assert property (@(posedge clk) disable iff (rst)
        (we && !soft_clr && wr_data[5]) |=> (att_right == {AT{1'b1}}));
    a_r8_master_default: assert property (@(posedge clk) disable iff (rst)
        soft_clr |=> (rd_word == MASTER_DEFAULT));
    a_r5_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_word[14:13] == 2'b00) && (rd_word[6:5] == 2'b00));
    a_r6_shared_mute: assert property (@(posedge clk) disable iff (rst)
        !split |-> (mute_right == mute_left) && (rd_word[7] == 1'b0));
endmodule

// File: rtl/mixreg_top.sv
module mixreg_top
    import mixreg_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int AT = ATT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data,
    output logic [AT-1:0] att_left,
    output logic [AT-1:0] att_right,
    output logic          mute_left,
    output logic          mute_right
);
    sel_t          sel;
    logic          hit;
    logic          soft_clr;
    logic [DW-1:0] serial_q;
    logic [DW-1:0] misc_q;
    logic [DW-1:0] master_word;
    logic [DW-1:0] rd_next;

    mixreg_decode #(.AW(AW)) dec_i (
        .addr (addr),
        .sel  (sel),
        .hit  (hit)
    );

    assign soft_clr = wr_en & sel.ident;

    mixreg_store #(.W(DW), .DEFAULT(SERIAL_DEFAULT), .KEEP_ON_SOFT(1'b1)) serial_i (
        .clk      (clk),
        .rst      (rst),
        .soft_clr (soft_clr),
        .we       (wr_en & sel.serial),
        .d        (wr_data),
        .q        (serial_q)
    );

    mixreg_store #(.W(DW), .DEFAULT(MISC_DEFAULT), .KEEP_ON_SOFT(1'b0)) misc_i (
        .clk      (clk),
        .rst      (rst),
        .soft_clr (soft_clr),
        .we       (wr_en & sel.misc),
        .d        (wr_data),
        .q        (misc_q)
    );

    mixreg_master #(.DW(DW), .AT(AT)) master_i (
        .clk        (clk),
        .rst        (rst),
        .soft_clr   (soft_clr),
        .we         (wr_en & sel.master),
        .wr_data    (wr_data),
        .split      (misc_q[SPLIT_BIT]),
        .rd_word    (master_word),
        .att_left   (att_left),
        .att_right  (att_right),
        .mute_left  (mute_left),
        .mute_right (mute_right)
    );

    always_comb begin
        rd_next = '0;
        if (hit) begin
            unique case (1'b1)
                sel.ident:  rd_next = IDENT_WORD;
                sel.master: rd_next = master_word;
                sel.serial: rd_next = serial_q;
                sel.misc:   rd_next = misc_q;
                default:    rd_next = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        rd_data <= '0;
        else if (rd_en) rd_data <= rd_next;
    end

    a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !hit) |=> (rd_data == '0));
    a_r2_ident_word: assert property (@(posedge clk) disable iff (rst)
        (rd_en && sel.ident) |=> (rd_data == IDENT_WORD));
    a_r11_hold_idle: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));
    a_r7_split_mute: assert property (@(posedge clk) disable iff (rst)
        misc_q[SPLIT_BIT] |-> (mute_right == master_word[7]));
endmodule

// File: tb/mixreg_top_tb_top.sv
module mixreg_top_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [6:0]  addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic [4:0]  att_left, att_right;
    logic        mute_left, mute_right;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mixreg_top dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .att_left(att_left),
        .att_right(att_right), .mute_left(mute_left), .mute_right(mute_right)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [15:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic chk_rd(input string req, input logic [6:0] a, input logic [15:0] exp);
        logic [15:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    function automatic logic [15:0] vol_exp(input logic [15:0] d, input logic split);
        logic [4:0] l, r;
        l = d[13] ? 5'd31 : d[12:8];
        r = d[5]  ? 5'd31 : d[4:0];
        return {d[15], 2'b00, l, d[7] & split, 2'b00, r};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual 0x0001 expected 0x0000");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] v, d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 att_left", {11'd0, att_left}, 16'd0);
        chk("R1 att_right", {11'd0, att_right}, 16'd0);
        chk("R1 mutes", {14'd0, mute_left, mute_right}, 16'd3);
        chk("R1 rd_data", rd_data, 16'h0000);
        chk_rd("R1 master", 7'h02, 16'h8000);
        chk_rd("R1 serial", 7'h74, 16'h0000);
        chk_rd("R1 misc", 7'h76, 16'h0000);
        chk_rd("R2 ident", 7'h00, 16'h0090);

        // R3 field sweep, R11 write then read next cycle
        for (int c = 0; c < 32; c++) begin
            d = {c[0], 2'b00, c[4:0], 1'b0, 2'b00, 5'(31 - c)};
            wr(7'h02, d);
            chk("R3 att_left", {11'd0, att_left}, 16'(c));
            chk("R3 att_right", {11'd0, att_right}, 16'(31 - c));
            chk("R3 mute_left", {15'd0, mute_left}, {15'd0, c[0]});
            chk_rd("R11 R3 readback", 7'h02, vol_exp(d, 1'b0));
        end

        // R4 legacy sixth bit saturation
        for (int k = 0; k < 4; k++) begin
            d = {1'b0, 1'b0, k[1], 5'b00110, 1'b0, 1'b0, k[0], 5'b01001};
            wr(7'h02, d);
            chk("R4 att_left", {11'd0, att_left}, k[1] ? 16'd31 : 16'd6);
            chk("R4 att_right", {11'd0, att_right}, k[0] ? 16'd31 : 16'd9);
            chk_rd("R4 readback", 7'h02, vol_exp(d, 1'b0));
        end

        // R5 reserved bits read zero
        wr(7'h02, 16'hFFFF);
        chk_rd("R5 R6 all ones split clear", 7'h02, 16'h9F1F);

        // R6 / R7 mute routing
        for (int k = 0; k < 8; k++) begin
            wr(7'h76, {3'b000, k[2], 12'h000});
            d = {k[1], 7'h00, k[0], 7'h00};
            wr(7'h02, d);
            if (k[2]) begin
                chk("R7 mute_left", {15'd0, mute_left}, {15'd0, k[1]});
                chk("R7 mute_right", {15'd0, mute_right}, {15'd0, k[0]});
            end else begin
                chk("R6 mute_left", {15'd0, mute_left}, {15'd0, k[1]});
                chk("R6 mute_right", {15'd0, mute_right}, {15'd0, k[1]});
            end
            chk_rd(k[2] ? "R7 readback" : "R6 readback", 7'h02, vol_exp(d, k[2]));
        end
        wr(7'h02, 16'hFFFF);
        chk_rd("R5 R7 all ones split set", 7'h02, 16'h9F9F);

        // R9 full-width storage, R8 soft reset
        wr(7'h74, 16'hA5C3);
        wr(7'h76, 16'h5A3C);
        chk_rd("R9 serial", 7'h74, 16'hA5C3);
        chk_rd("R9 misc", 7'h76, 16'h5A3C);
        wr(7'h02, 16'h0A05);
        wr(7'h00, 16'h1234);
        chk("R8 mutes", {14'd0, mute_left, mute_right}, 16'd3);
        chk("R8 att_left", {11'd0, att_left}, 16'd0);
        chk_rd("R8 master", 7'h02, 16'h8000);
        chk_rd("R8 misc", 7'h76, 16'h0000);
        chk_rd("R9 serial kept", 7'h74, 16'hA5C3);
        chk_rd("R2 ident after soft reset", 7'h00, 16'h0090);

        // R10 unmapped indices
        wr(7'h76, 16'h1001);
        wr(7'h02, 16'h8485);
        for (int a = 0; a < 128; a++) begin
            if (a != 'h00 && a != 'h02 && a != 'h74 && a != 'h76) begin
                wr(7'(a), 16'hFFFF);
                chk_rd("R10 unmapped read", 7'(a), 16'h0000);
            end
        end
        chk_rd("R10 master untouched", 7'h02, 16'h8485);
        chk_rd("R10 serial untouched", 7'h74, 16'hA5C3);
        chk_rd("R10 misc untouched", 7'h76, 16'h1001);
        chk("R10 att ports", {6'd0, att_left, att_right}, {6'd0, 5'd4, 5'd5});

        // R11 hold while rd_en low
        rd(7'h74, v);
        @(negedge clk);
        addr = 7'h00;
        @(negedge clk);
        @(negedge clk);
        chk("R11 hold", rd_data, 16'hA5C3);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule